// File: doc/BRIEF.md
# Transport-Triggered Function Unit Cluster

This block is a set of execution units that hang off a move-only processor bus. There are no opcodes. A move that writes a unit's input register starts that unit's work. A later move reads the result from one of the cluster's source addresses. Each cycle the bus can make one write into the cluster through the destination port and one read out of it through the source port. A single move instruction can therefore take a result from one unit and feed it to another in the same cycle.

The cluster holds five units:

- **Adder.** Two operands, with a registered sum and a carry flag. Its result lands a fixed number of cycles after the most recent operand write. An addition is therefore two operand moves and one later read, and code must schedule the read after the latency.
- **Inverter.** Returns the bitwise complement of its input.
- **Zero tester.** Reports whether its input is zero.
- **Barrel shifter.** Left or right, with zero fill.
- **Pseudo-random source.** An 8-bit linear feedback shift register that steps once for each read of it.

Both flag results (zero test and adder carry) read as 8'h01 when true and 8'h00 when false, so a conditional branch can test them directly.

Top module: `fu_cluster`

## Requirements
- R1: A read of source 0 returns (A + B) mod 256 and a read of source 1 returns 8'h01 when A + B exceeds 255, else 8'h00. A and B are the values most recently written to destinations 0 and 1, and the read is made once the latency of R2 has elapsed.
- R2: After an operand write at clock edge k, sources 0 and 1 keep their previous values through the cycles that follow edges k and k+1. The new result is readable from the cycle after edge k+2, which is the default latency of 2 cycles.
- R3: An operand write while a result is still pending restarts the latency count. The result then appears two edges after that later write, and no intermediate sum is ever exposed.
- R4: A read of source 2 returns the bitwise complement of the value last written to destination 2, from the cycle after that write.
- R5: A read of source 3 returns 8'h01 if the value last written to destination 3 is zero, otherwise 8'h00, from the cycle after that write.
- R6: A read of source 4 returns the value last written to destination 4, shifted by the value last written to destination 5. Bits [2:0] of destination 5 give the distance; bit 3 selects right (1) or left (0). Vacated positions fill with zeros.
- R7: Source 5 returns the generator state, which starts at 8'h5A after reset. Each clock edge that sees rd_en high with source 5 selected moves the state s to {s[6:0], s[7]^s[5]^s[4]^s[3]}. The polynomial is x^8+x^6+x^5+x^4+1. Reads of other sources, and cycles with rd_en low, leave the state unchanged, and the state is never zero.
- R8: After reset, sources 0 to 5 read 8'h00, 8'h00, 8'hFF, 8'h01, 8'h00 and 8'h5A.
- R9: Source addresses 6 to 31 read 8'h00. Writes to destination addresses 6 to 31 change no source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Destination write strobe for this cycle |
| wr_addr | input | 5 | Destination address of the move |
| wr_data | input | 8 | Value being moved in |
| rd_en | input | 1 | Source read strobe; it steps the random source when that source is selected |
| rd_addr | input | 5 | Source address of the move |
| rd_data | output | 8 | Combinational value of the selected source |

## Verification
If the adder's latency counter is wrong, the sum at source 0 changes one edge early or one edge late relative to the second edge after the last operand write. The bench reads on both sides of that edge, so the error shows up within one cycle. A wrong feedback tap or a wrong step condition in the random source makes the sequence at source 5 drift from the bench model. The divergence appears at the first read after the fault, or at the read after a cycle that should not have stepped the state. Errors in the shift direction, the fill or the flag encoding show at the next read of the affected source, because every source is combinational from its registered input.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int FU_DATA_W = 8;
  localparam int FU_ADDR_W = 5;

  // Shared bus codes: a destination code names a unit input and the same
  // source code names that unit's output.
  localparam int PORT_ADD_A  = 0;  // dst: operand A   src: sum
  localparam int PORT_ADD_B  = 1;  // dst: operand B   src: carry flag
  localparam int PORT_INV    = 2;  // dst: inv input   src: complement
  localparam int PORT_ZT     = 3;  // dst: test input  src: zero flag
  localparam int PORT_SH_VAL = 4;  // dst: shift value src: shifted value
  localparam int PORT_SH_CTL = 5;  // dst: shift ctrl  src: random value
  localparam int PORT_RND    = 5;

  typedef struct packed {
    logic wr_a;
    logic wr_b;
    logic wr_inv;
    logic wr_zt;
    logic wr_shv;
    logic wr_shc;
  } fu_wdec_t;
endpackage

// File: rtl/fu_rst_sync.sv
module fu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fu_adder.sv
module fu_adder #(
  parameter int DATA_W = 8,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic              b_we,
  input  logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] sum,
  output logic              carry
);
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [DATA_W-1:0] a_q, b_q;
  logic [DATA_W:0]   res_q, res_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              op_we, latch_en;

  assign op_we    = a_we | b_we;
  assign latch_en = !op_we && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (op_we)              cnt_d = CNT_LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_LAST;
  end

  always_comb begin
    res_d = {1'b0, a_q} + {1'b0, b_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (a_we) begin
      a_q <= op_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
    end else if (b_we) begin
      b_q <= op_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (latch_en) begin
      res_q <= res_d;
    end
  end

  assign sum   = res_q[DATA_W-1:0];
  assign carry = res_q[DATA_W];

  AST_ADD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |=> (cnt_q == CNT_LOAD)); // R3
  AST_ADD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_LAST || op_we) |=> $stable(res_q)); // R2
endmodule

// File: rtl/fu_shifter.sv
module fu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]         val,
  input  logic [$clog2(DATA_W):0]   ctl,
  output logic [DATA_W-1:0]         res
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [AMT_W+1];
  logic              dir_right;

  assign dir_right = ctl[AMT_W];
  assign stage[0]  = val;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    always_comb begin
      if (!ctl[i])        stage[i+1] = stage[i];
      else if (dir_right) stage[i+1] = stage[i] >> (1 << i);
      else                stage[i+1] = stage[i] << (1 << i);
    end
  end

  assign res = stage[AMT_W];
endmodule

// File: rtl/fu_lfsr.sv
module fu_lfsr #(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED = 8'h5A,
  parameter logic [DATA_W-1:0] TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [DATA_W-1:0] state
);
  logic [DATA_W-1:0] st_q, st_d;
  logic              fb;

  assign fb = ^(st_q & TAPS);

  always_comb begin
    st_d = {st_q[DATA_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else if (adv) begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

  AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R7
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st_q)); // R7
endmodule

// File: rtl/fu_cluster.sv
module fu_cluster #(
  parameter int                DATA_W   = fu_pkg::FU_DATA_W,
  parameter int                ADDR_W   = fu_pkg::FU_ADDR_W,
  parameter int                ADD_LAT  = 2,
  parameter logic [DATA_W-1:0] RND_SEED = 8'h5A,
  parameter logic [DATA_W-1:0] RND_TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import fu_pkg::*;

  localparam int CTL_W = $clog2(DATA_W) + 1;
  localparam logic [DATA_W-1:0] FLAG_ONE = DATA_W'(1);

  logic              rst_q_n;
  fu_wdec_t          wdec;
  logic [DATA_W-1:0] sum, inv_q, zt_q, shv_q, sh_res, rnd;
  logic [CTL_W-1:0]  shc_q;
  logic              carry, rnd_adv;
  logic [DATA_W-1:0] inv_out, zt_out, carry_out;

  fu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  always_comb begin
    wdec.wr_a   = wr_en && (wr_addr == ADDR_W'(PORT_ADD_A));
    wdec.wr_b   = wr_en && (wr_addr == ADDR_W'(PORT_ADD_B));
    wdec.wr_inv = wr_en && (wr_addr == ADDR_W'(PORT_INV));
    wdec.wr_zt  = wr_en && (wr_addr == ADDR_W'(PORT_ZT));
    wdec.wr_shv = wr_en && (wr_addr == ADDR_W'(PORT_SH_VAL));
    wdec.wr_shc = wr_en && (wr_addr == ADDR_W'(PORT_SH_CTL));
  end

  fu_adder #(.DATA_W(DATA_W), .LAT(ADD_LAT)) u_add (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .a_we    (wdec.wr_a),
    .b_we    (wdec.wr_b),
    .op_data (wr_data),
    .sum     (sum),
    .carry   (carry)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)         inv_q <= '0;
    else if (wdec.wr_inv) inv_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)        zt_q <= '0;
    else if (wdec.wr_zt) zt_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)         shv_q <= '0;
    else if (wdec.wr_shv) shv_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)         shc_q <= '0;
    else if (wdec.wr_shc) shc_q <= wr_data[CTL_W-1:0];
  end

  fu_shifter #(.DATA_W(DATA_W)) u_sh (
    .val (shv_q),
    .ctl (shc_q),
    .res (sh_res)
  );

  assign rnd_adv = rd_en && (rd_addr == ADDR_W'(PORT_RND));

  fu_lfsr #(.DATA_W(DATA_W), .SEED(RND_SEED), .TAPS(RND_TAPS)) u_rnd (
    .clk   (clk),
    .rst_n (rst_q_n),
    .adv   (rnd_adv),
    .state (rnd)
  );

  assign inv_out   = ~inv_q;
  assign zt_out    = (zt_q == '0) ? FLAG_ONE : '0;
  assign carry_out = carry ? FLAG_ONE : '0;

  always_comb begin
    case (rd_addr)
      ADDR_W'(PORT_ADD_A):  rd_data = sum;
      ADDR_W'(PORT_ADD_B):  rd_data = carry_out;
      ADDR_W'(PORT_INV):    rd_data = inv_out;
      ADDR_W'(PORT_ZT):     rd_data = zt_out;
      ADDR_W'(PORT_SH_VAL): rd_data = sh_res;
      ADDR_W'(PORT_RND):    rd_data = rnd;
      default:              rd_data = '0;
    endcase
  end

  AST_INV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    wdec.wr_inv |=> (inv_out == ~$past(wr_data))); // R4
  AST_ZT_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    wdec.wr_zt |=> (zt_out == (($past(wr_data) == '0) ? FLAG_ONE : '0))); // R5
  AST_CARRY_RANGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_addr == ADDR_W'(PORT_ADD_B)) |-> (rd_data[DATA_W-1:1] == '0)); // R1
  AST_SH_IDENT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (shc_q[CTL_W-2:0] == '0) |-> (sh_res == shv_q)); // R6
endmodule

// File: tb/fu_cluster_test.sv
module fu_cluster_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_rnd;
  logic [7:0] m_sum, m_carry;

  always #10 clk = ~clk;

  fu_cluster uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  function automatic logic [7:0] f_lfsr(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] f_shift(input logic [7:0] v, input logic [7:0] c);
    return c[3] ? (v >> c[2:0]) : (v << c[2:0]);
  endfunction

  function automatic logic [8:0] f_add(input logic [7:0] a, input logic [7:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Called just after a negedge; the write is taken at the next posedge.
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // Combinational read with no strobe.
  task automatic peek(input logic [4:0] a, output logic [7:0] v);
    rd_en = 1'b0; rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic rnd_read(input string req);
    logic [7:0] v;
    rd_en = 1'b1; rd_addr = 5'd5;
    #1 v = rd_data;
    check(req, v, m_rnd);
    @(negedge clk);
    rd_en = 1'b0;
    m_rnd = f_lfsr(m_rnd);
  endtask

  task automatic add_check(input string req);
    logic [7:0] v;
    peek(5'd0, v); check(req, v, m_sum);
    peek(5'd1, v); check(req, v, m_carry);
  endtask

  initial begin
    logic [7:0] v, a, b, d, c, sv;
    logic [8:0] r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    m_rnd = 8'h5A; m_sum = 8'h00; m_carry = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset values
    peek(5'd0, v); check("R8 sum", v, 8'h00);
    peek(5'd1, v); check("R8 carry", v, 8'h00);
    peek(5'd2, v); check("R8 inv", v, 8'hFF);
    peek(5'd3, v); check("R8 zt", v, 8'h01);
    peek(5'd4, v); check("R8 shift", v, 8'h00);
    peek(5'd5, v); check("R8 rnd", v, 8'h5A);

    // R9 unmapped reads and writes
    peek(5'd31, v); check("R9 read", v, 8'h00);
    peek(5'd6, v);  check("R9 read", v, 8'h00);
    wr(5'd7, 8'hC3);
    wr(5'd31, 8'h00);
    idle(); idle();
    peek(5'd0, v); check("R9 sum", v, 8'h00);
    peek(5'd2, v); check("R9 inv", v, 8'hFF);
    peek(5'd3, v); check("R9 zt", v, 8'h01);
    peek(5'd4, v); check("R9 shift", v, 8'h00);
    peek(5'd5, v); check("R9 rnd", v, 8'h5A);

    // R1/R2 directed carry corner: FF + 01
    wr(5'd0, 8'hFF);
    wr(5'd1, 8'h01);            // now after edge k
    add_check("R2 edge k");
    idle();                     // after edge k+1
    add_check("R2 edge k+1");
    idle();                     // after edge k+2
    m_sum = 8'h00; m_carry = 8'h01;
    add_check("R1 carry");

    // R3 restart: A write, one idle, B write
    wr(5'd0, 8'h10);
    idle();
    wr(5'd1, 8'h22);            // restart at this edge
    add_check("R3 no early");
    idle();
    add_check("R3 still old");
    idle();
    m_sum = 8'h32; m_carry = 8'h00;
    add_check("R3 landed");

    // R6 directed corners
    wr(5'd4, 8'h81);
    wr(5'd5, 8'h07);
    peek(5'd4, v); check("R6 left 7", v, 8'h80);
    wr(5'd5, 8'h0F);
    peek(5'd4, v); check("R6 right 7", v, 8'h01);
    wr(5'd5, 8'h08);
    peek(5'd4, v); check("R6 right 0", v, 8'h81);

    // R5 directed
    wr(5'd3, 8'h00);
    peek(5'd3, v); check("R5 zero", v, 8'h01);
    wr(5'd3, 8'h80);
    peek(5'd3, v); check("R5 nonzero", v, 8'h00);

    // R7: read of another source with strobe must not step
    rd_en = 1'b1; rd_addr = 5'd2;
    @(negedge clk);
    rd_en = 1'b0;
    rnd_read("R7 no step");
    rnd_read("R7 step");

    // Random mix
    for (int i = 0; i < 150; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      if (i % 10 == 0) b = 8'h00;
      wr(5'd0, a);
      wr(5'd1, b);
      add_check("R2 hold");
      idle();
      add_check("R2 hold");
      idle();
      r = f_add(a, b);
      m_sum = r[7:0]; m_carry = {7'b0, r[8]};
      add_check("R1 sum");

      d = 8'($urandom);
      wr(5'd2, d);
      peek(5'd2, v); check("R4 inv", v, ~d);

      d = (i % 7 == 0) ? 8'h00 : 8'($urandom);
      wr(5'd3, d);
      peek(5'd3, v); check("R5 zt", v, (d == 8'h00) ? 8'h01 : 8'h00);

      sv = 8'($urandom); c = 8'($urandom);
      wr(5'd4, sv);
      wr(5'd5, c);
      peek(5'd4, v); check("R6 shift", v, f_shift(sv, c));

      if (i % 3 == 0) idle();
      rnd_read("R7 seq");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule